// File: doc/BRIEF.md
# SRAM Test Packet Register

This block holds a single 112-bit test packet that drives both ports of one memory out of a bank of on-chip SRAMs. It is used to exercise the memories from outside the chip. The packet can be filled in two ways. In serial mode it is shifted in one bit at a time through a scan pin, while the previous packet leaves through a scan output. In parallel mode it is copied in one step from a 128-bit logic-analyzer word, whose top bits carry the control strobes.

After a read has been set up, a load strobe writes the data output of each reading port back into that port's data field of the packet. The result can then be shifted out, or read on the parallel readback bus. The block decodes the packet's memory-select field into per-memory chip selects. It sends the address, data and write controls on shared buses, and folds the 32-bit data field onto the single 64-bit-wide memory.

All slow control inputs (mode, scan clock, scan enable, scan data, scan load and the three control bits of the analyzer word) pass through a synchronizer into the system clock domain. Their rising edges act as strobes. The memories run on the same system clock. The interface has no handshake and no back-pressure. A strobe edge is always accepted, and the driver must hold data steady around each edge.

Top module: `sram_tpkt_top`

## Requirements
- R1: While `scan_rst_n` is low, the packet equals all zeros except the port-0 disable bit (59) and the port-1 disable bit (8), which are 1. Every memory chip select is therefore high, and `scan_out` is 0.
- R2: Packet bit positions, from MSB to LSB, are: memory select [111:108], port-0 address [107:92], port-0 data [91:60], port-0 disable [59], port-0 write-low [58], port-0 mask [57], port-1 address [56:41], port-1 data [40:9], port-1 disable [8], port-1 write-low [7], port-1 mask [6:3], reserved [2:0]. `pkt_rd` shows the packet in this layout.
- R3: In serial mode (`mode_sel`=1), each rising edge of `scan_clk` with `scan_en` high shifts the packet one place toward the MSB, with `scan_in` entering bit 0. `scan_out` always shows bit 111. So 112 edges load a full packet sent MSB first and return the old packet MSB first.
- R4: A `scan_clk` rising edge with both `scan_en` and `scan_load` low leaves the packet unchanged.
- R5: In parallel mode (`mode_sel`=0), a rising edge of `la_word[127]` while `la_word[125]` is high copies `la_word[111:3]` into packet bits [111:3] and clears bits [2:0].
- R6: Analyzer control edges have no effect in serial mode, and scan edges have no effect in parallel mode.
- R7: The result-capture strobe is `scan_load` on a scan edge with `scan_en` low (serial mode), or `la_word[124]` on an analyzer clock edge with `la_word[125]` low (parallel mode). It overwrites the data field of every port that is reading, meaning its chip select is low and its write-low bit is 1, with that port's memory output. All other fields stay as they are.
- R8: Select values 0 to NUM_MEM-1 may pull low only the chip selects of that memory, and each port only when its disable bit is 0. Select values NUM_MEM and above select nothing.
- R9: While `glob_csb` is high, all chip selects are high, whatever the packet holds.
- R10: Memories without a second port (default: indices 5 to 8) keep their port-1 chip select high.
- R11: A narrow memory sees data {32'h0, field}. The wide memory (default: index 8) sees {field[31:16], 32'h0, field[15:0]}, and its output word w is read back as {w[63:48], w[15:0]}.
- R12: The address buses carry the address fields. `mem_wmask0` is four copies of the port-0 mask bit, and `mem_wmask1` is the port-1 mask field. The write-low outputs carry the write-low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and memory clock |
| scan_rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | 1 selects serial mode, 0 selects parallel mode |
| scan_clk | input | 1 | Scan clock, sampled for rising edges |
| scan_en | input | 1 | Shift enable |
| scan_in | input | 1 | Serial data in |
| scan_load | input | 1 | Serial result-capture request |
| scan_out | output | 1 | Serial data out (packet bit 111) |
| la_word | input | 128 | Analyzer word: packet bits and control bits 127/125/124 |
| glob_csb | input | 1 | Global disable for all memories |
| pkt_rd | output | 112 | Current packet |
| mem_csb0 | output | NUM_MEM | Port-0 chip selects, active low |
| mem_csb1 | output | NUM_MEM | Port-1 chip selects, active low |
| mem_web0 | output | 1 | Port-0 write-low |
| mem_wmask0 | output | 4 | Port-0 write mask |
| mem_addr0 | output | 16 | Port-0 address |
| mem_din0 | output | 64 | Port-0 write data |
| mem_web1 | output | 1 | Port-1 write-low |
| mem_wmask1 | output | 4 | Port-1 write mask |
| mem_addr1 | output | 16 | Port-1 address |
| mem_din1 | output | 64 | Port-1 write data |
| mem_dout0 | input | NUM_MEM*64 | Port-0 outputs of all memories, memory m at [m*64 +: 64] |
| mem_dout1 | input | NUM_MEM*64 | Port-1 outputs of all memories |

## Verification
A table of select values paired with port-disable patterns covers several distinct cases: memories with two ports, memories with one port, the wide memory, out-of-range selects and disabled ports. Each entry is checked against its expected chip-select vector. Write-then-read sequences on a narrow memory and on the wide memory separate correct folding from a plain 64-bit pass-through. They also show whether the capture fills only the ports that are reading. A full 112-bit scan confirms the bit order in both directions. Scan and analyzer edges applied in the wrong mode, or with the wrong control bits, show whether the packet is really left unchanged.

// File: rtl/tpkt_pkg.sv
package tpkt_pkg;
  localparam int PKT_W    = 112;
  localparam int LA_W     = 128;
  localparam int SEL_W    = 4;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = DATA_W / 2;
  localparam int WM1_W    = 4;
  localparam int WM0_OUT  = 4;
  localparam int RSV_W    = 3;
  localparam int MEM_W    = 64;
  localparam int GAP_W    = MEM_W - DATA_W;

  localparam int LA_CLK_BIT  = 127;
  localparam int LA_LOAD_BIT = 125;
  localparam int LA_CAP_BIT  = 124;

  // MSB-first layout; the serial order depends on it
  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] addr0;
    logic [DATA_W-1:0] din0;
    logic              csb0;
    logic              web0;
    logic              wmask0;
    logic [ADDR_W-1:0] addr1;
    logic [DATA_W-1:0] din1;
    logic              csb1;
    logic              web1;
    logic [WM1_W-1:0]  wmask1;
    logic [RSV_W-1:0]  rsv;
  } tpkt_t;

  localparam tpkt_t TPKT_RESET = '{csb0: 1'b1, csb1: 1'b1, default: '0};

  function automatic logic [MEM_W-1:0] fold_narrow(input logic [DATA_W-1:0] d);
    return {{GAP_W{1'b0}}, d};
  endfunction

  function automatic logic [MEM_W-1:0] fold_wide(input logic [DATA_W-1:0] d);
    return {d[DATA_W-1:HALF_W], {GAP_W{1'b0}}, d[HALF_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] unfold_wide(input logic [MEM_W-1:0] w);
    return {w[MEM_W-1 -: HALF_W], w[HALF_W-1:0]};
  endfunction
endpackage

// File: rtl/tpkt_sync.sv
module tpkt_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tpkt_store.sv
module tpkt_store
  import tpkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_go,
  input  logic              shift_bit,
  input  logic              load_go,
  input  tpkt_t             load_val,
  input  logic              cap_go,
  input  logic              cap0_en,
  input  logic              cap1_en,
  input  logic [DATA_W-1:0] cap0_data,
  input  logic [DATA_W-1:0] cap1_data,
  output tpkt_t             q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= TPKT_RESET;
    end else if (shift_go) begin
      q <= tpkt_t'({q[PKT_W-2:0], shift_bit});
    end else if (load_go) begin
      q     <= load_val;
      q.rsv <= '0;
    end else if (cap_go) begin
      if (cap0_en) q.din0 <= cap0_data;
      if (cap1_en) q.din1 <= cap1_data;
    end
  end
endmodule

// File: rtl/tpkt_port_map.sv
module tpkt_port_map
  import tpkt_pkg::*;
#(
  parameter int                 NUM_MEM   = 9,
  parameter logic [NUM_MEM-1:0] WIDE_MASK = 9'h100,
  parameter logic [NUM_MEM-1:0] DUAL_MASK = 9'h01F
) (
  input  tpkt_t                      pkt,
  input  logic                       glob_csb,
  input  logic [NUM_MEM*MEM_W-1:0]   mem_dout0,
  input  logic [NUM_MEM*MEM_W-1:0]   mem_dout1,
  output logic [NUM_MEM-1:0]         mem_csb0,
  output logic [NUM_MEM-1:0]         mem_csb1,
  output logic                       mem_web0,
  output logic [WM0_OUT-1:0]         mem_wmask0,
  output logic [ADDR_W-1:0]          mem_addr0,
  output logic [MEM_W-1:0]           mem_din0,
  output logic                       mem_web1,
  output logic [WM1_W-1:0]           mem_wmask1,
  output logic [ADDR_W-1:0]          mem_addr1,
  output logic [MEM_W-1:0]           mem_din1,
  output logic [DATA_W-1:0]          rd0_data,
  output logic [DATA_W-1:0]          rd1_data,
  output logic                       rd0_act,
  output logic                       rd1_act
);
  logic [NUM_MEM-1:0] sel_oh;
  logic [NUM_MEM-1:0] hit;
  logic               sel_wide;
  logic [MEM_W-1:0]   word0;
  logic [MEM_W-1:0]   word1;
  logic [RSV_W-1:0]   unused_rsv;

  assign unused_rsv = pkt.rsv;

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    assign sel_oh[m]   = (pkt.sel == SEL_W'(m));
    assign hit[m]      = sel_oh[m] & ~glob_csb;
    assign mem_csb0[m] = ~(hit[m] & ~pkt.csb0);
    if (DUAL_MASK[m]) begin : g_dual
      assign mem_csb1[m] = ~(hit[m] & ~pkt.csb1);
    end else begin : g_single
      assign mem_csb1[m] = 1'b1;
    end
  end

  assign sel_wide = |(sel_oh & WIDE_MASK);

  always_comb begin
    word0 = '0;
    word1 = '0;
    for (int m = 0; m < NUM_MEM; m++) begin
      if (sel_oh[m]) begin
        word0 = mem_dout0[m*MEM_W +: MEM_W];
        word1 = mem_dout1[m*MEM_W +: MEM_W];
      end
    end
  end

  assign mem_din0   = sel_wide ? fold_wide(pkt.din0) : fold_narrow(pkt.din0);
  assign mem_din1   = sel_wide ? fold_wide(pkt.din1) : fold_narrow(pkt.din1);
  assign rd0_data   = sel_wide ? unfold_wide(word0) : word0[DATA_W-1:0];
  assign rd1_data   = sel_wide ? unfold_wide(word1) : word1[DATA_W-1:0];

  assign mem_web0   = pkt.web0;
  assign mem_wmask0 = {WM0_OUT{pkt.wmask0}};
  assign mem_addr0  = pkt.addr0;
  assign mem_web1   = pkt.web1;
  assign mem_wmask1 = pkt.wmask1;
  assign mem_addr1  = pkt.addr1;

  assign rd0_act = ~(&mem_csb0) & pkt.web0;
  assign rd1_act = ~(&mem_csb1) & pkt.web1;
endmodule

// File: rtl/sram_tpkt_top.sv
module sram_tpkt_top
  import tpkt_pkg::*;
#(
  parameter int                 NUM_MEM     = 9,
  parameter logic [NUM_MEM-1:0] WIDE_MASK   = 9'h100,
  parameter logic [NUM_MEM-1:0] DUAL_MASK   = 9'h01F,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       scan_rst_n,
  input  logic                       mode_sel,
  input  logic                       scan_clk,
  input  logic                       scan_en,
  input  logic                       scan_in,
  input  logic                       scan_load,
  output logic                       scan_out,
  input  logic [LA_W-1:0]            la_word,
  input  logic                       glob_csb,
  output logic [PKT_W-1:0]           pkt_rd,
  output logic [NUM_MEM-1:0]         mem_csb0,
  output logic [NUM_MEM-1:0]         mem_csb1,
  output logic                       mem_web0,
  output logic [WM0_OUT-1:0]         mem_wmask0,
  output logic [ADDR_W-1:0]          mem_addr0,
  output logic [MEM_W-1:0]           mem_din0,
  output logic                       mem_web1,
  output logic [WM1_W-1:0]           mem_wmask1,
  output logic [ADDR_W-1:0]          mem_addr1,
  output logic [MEM_W-1:0]           mem_din1,
  input  logic [NUM_MEM*MEM_W-1:0]   mem_dout0,
  input  logic [NUM_MEM*MEM_W-1:0]   mem_dout1
);
  localparam int CTL_W = 8;

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic mode_s, sclk_s, sen_s, sin_s, sload_s, lclk_s, lload_s, lcap_s;
  logic sclk_prev, lclk_prev, sclk_rise, lclk_rise;
  logic shift_go, load_go, cap_go;
  logic rd0_act, rd1_act;
  logic [DATA_W-1:0] rd0_data, rd1_data;
  tpkt_t pkt_q;
  logic unused_la;

  assign unused_la = ^{la_word[LA_W-2], la_word[LA_CAP_BIT-1:PKT_W]};

  assign ctl_raw = {mode_sel, scan_clk, scan_en, scan_in, scan_load,
                    la_word[LA_CLK_BIT], la_word[LA_LOAD_BIT], la_word[LA_CAP_BIT]};

  tpkt_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (scan_rst_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  assign {mode_s, sclk_s, sen_s, sin_s, sload_s, lclk_s, lload_s, lcap_s} = ctl_s;

  always_ff @(posedge clk or negedge scan_rst_n) begin
    if (!scan_rst_n) begin
      sclk_prev <= 1'b0;
      lclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      lclk_prev <= lclk_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign lclk_rise = lclk_s & ~lclk_prev;

  assign shift_go = mode_s & sclk_rise & sen_s;
  assign load_go  = ~mode_s & lclk_rise & lload_s;
  assign cap_go   = (mode_s & sclk_rise & ~sen_s & sload_s) |
                    (~mode_s & lclk_rise & ~lload_s & lcap_s);

  tpkt_store u_store (
    .clk       (clk),
    .rst_n     (scan_rst_n),
    .shift_go  (shift_go),
    .shift_bit (sin_s),
    .load_go   (load_go),
    .load_val  (tpkt_t'(la_word[PKT_W-1:0])),
    .cap_go    (cap_go),
    .cap0_en   (rd0_act),
    .cap1_en   (rd1_act),
    .cap0_data (rd0_data),
    .cap1_data (rd1_data),
    .q         (pkt_q)
  );

  tpkt_port_map #(.NUM_MEM(NUM_MEM), .WIDE_MASK(WIDE_MASK), .DUAL_MASK(DUAL_MASK)) u_map (
    .pkt        (pkt_q),
    .glob_csb   (glob_csb),
    .mem_dout0  (mem_dout0),
    .mem_dout1  (mem_dout1),
    .mem_csb0   (mem_csb0),
    .mem_csb1   (mem_csb1),
    .mem_web0   (mem_web0),
    .mem_wmask0 (mem_wmask0),
    .mem_addr0  (mem_addr0),
    .mem_din0   (mem_din0),
    .mem_web1   (mem_web1),
    .mem_wmask1 (mem_wmask1),
    .mem_addr1  (mem_addr1),
    .mem_din1   (mem_din1),
    .rd0_data   (rd0_data),
    .rd1_data   (rd1_data),
    .rd0_act    (rd0_act),
    .rd1_act    (rd1_act)
  );

  assign pkt_rd   = pkt_q;
  assign scan_out = pkt_q[PKT_W-1];
endmodule

// File: rtl/sram_tpkt_chk.sv
module sram_tpkt_chk
  import tpkt_pkg::*;
#(
  parameter int                 NUM_MEM   = 9,
  parameter logic [NUM_MEM-1:0] WIDE_MASK = 9'h100,
  parameter logic [NUM_MEM-1:0] DUAL_MASK = 9'h01F
) (
  input logic               clk,
  input logic               scan_rst_n,
  input logic               glob_csb,
  input logic [NUM_MEM-1:0] mem_csb0,
  input logic [NUM_MEM-1:0] mem_csb1,
  input logic [MEM_W-1:0]   mem_din0,
  input logic               shift_go,
  input logic               load_go,
  input logic               cap_go,
  input logic [PKT_W-1:0]   pkt_rd
);
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!scan_rst_n)
    glob_csb |-> (&mem_csb0 && &mem_csb1));  // R9
  AST_ONE_MEMORY: assert property (@(posedge clk) disable iff (!scan_rst_n)
    $onehot0(~mem_csb0 | ~mem_csb1));  // R8
  AST_SINGLE_PORT_OFF: assert property (@(posedge clk) disable iff (!scan_rst_n)
    &(mem_csb1 | DUAL_MASK));  // R10
  AST_WIDE_GAP_ZERO: assert property (@(posedge clk) disable iff (!scan_rst_n)
    (|(~mem_csb0 & WIDE_MASK)) |-> (mem_din0[MEM_W-HALF_W-1:HALF_W] == '0));  // R11
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!scan_rst_n)
    shift_go |=> (pkt_rd[PKT_W-1:1] == $past(pkt_rd[PKT_W-2:0])));  // R3
  AST_RSV_CLEAR: assert property (@(posedge clk) disable iff (!scan_rst_n)
    load_go |=> (pkt_rd[RSV_W-1:0] == '0));  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!scan_rst_n)
    !(shift_go || load_go || cap_go) |=> $stable(pkt_rd));  // R4
  AST_CAPTURE_KEEP: assert property (@(posedge clk) disable iff (!scan_rst_n)
    (cap_go && !shift_go && !load_go) |=> $stable(pkt_rd[PKT_W-1:PKT_W-SEL_W-ADDR_W]));  // R7
endmodule

bind sram_tpkt_top sram_tpkt_chk #(
  .NUM_MEM(NUM_MEM), .WIDE_MASK(WIDE_MASK), .DUAL_MASK(DUAL_MASK)
) u_chk (.*);

// File: tb/sram_tpkt_top_tb.sv
module sram_tpkt_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 9;
  localparam int MW = 64;

  logic clk = 0, rst_n = 0, mode_sel = 0, scan_clk = 0, scan_en = 0, scan_in = 0, scan_load = 0;
  logic glob_csb = 0;
  logic [127:0] la_word = '0;
  logic scan_out, web0, web1;
  logic [111:0] pkt_rd;
  logic [NM-1:0] csb0, csb1;
  logic [3:0] wm0, wm1;
  logic [15:0] a0, a1;
  logic [63:0] d0, d1;
  logic [NM*MW-1:0] dout0, dout1;
  logic [63:0] mem [NM][16];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_tpkt_top u_dut (
    .clk(clk), .scan_rst_n(rst_n), .mode_sel(mode_sel), .scan_clk(scan_clk),
    .scan_en(scan_en), .scan_in(scan_in), .scan_load(scan_load), .scan_out(scan_out),
    .la_word(la_word), .glob_csb(glob_csb), .pkt_rd(pkt_rd),
    .mem_csb0(csb0), .mem_csb1(csb1), .mem_web0(web0), .mem_wmask0(wm0),
    .mem_addr0(a0), .mem_din0(d0), .mem_web1(web1), .mem_wmask1(wm1),
    .mem_addr1(a1), .mem_din1(d1), .mem_dout0(dout0), .mem_dout1(dout1)
  );

  // behavioural memories: write on port 0, registered reads on both ports
  always @(posedge clk) begin
    for (int m = 0; m < NM; m++) begin
      if (!csb0[m]) begin
        if (!web0 && wm0[0]) mem[m][a0[3:0]] <= d0;
        else                 dout0[m*MW +: MW] <= mem[m][a0[3:0]];
      end
      if (!csb1[m]) dout1[m*MW +: MW] <= mem[m][a1[3:0]];
    end
  end

  function automatic logic [111:0] mkpkt(
    input logic [3:0] sel, input logic [15:0] ad0, input logic [31:0] dd0,
    input logic c0, input logic w0, input logic k0,
    input logic [15:0] ad1, input logic [31:0] dd1,
    input logic c1, input logic w1, input logic [3:0] k1);
    return {sel, ad0, dd0, c0, w0, k0, ad1, dd1, c1, w1, k1, 3'b000};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic scan_pulse(input logic b, input logic en, input logic ld);
    scan_in = b; scan_en = en; scan_load = ld;
    tick(4); scan_clk = 1; tick(4); scan_clk = 0; tick(4);
  endtask

  task automatic la_pulse(input logic [127:0] w);
    la_word = w; la_word[127] = 1'b0;
    tick(4); la_word[127] = 1'b1; tick(4); la_word[127] = 1'b0; tick(4);
  endtask

  task automatic la_load(input logic [111:0] p);
    la_pulse({2'b00, 1'b1, 1'b0, 12'h0, p});
  endtask

  task automatic la_capture(input logic [111:0] p);
    la_pulse({2'b00, 1'b0, 1'b1, 12'h0, p});
  endtask

  // entries: {select, port0 disable, port1 disable, expected csb0, expected csb1}
  localparam logic [23:0] VEC [10] = '{
    {4'd0,  1'b0, 1'b0, 9'h1FE, 9'h1FE},
    {4'd3,  1'b0, 1'b0, 9'h1F7, 9'h1F7},
    {4'd4,  1'b0, 1'b1, 9'h1EF, 9'h1FF},
    {4'd5,  1'b0, 1'b0, 9'h1DF, 9'h1FF},
    {4'd8,  1'b0, 1'b0, 9'h0FF, 9'h1FF},
    {4'd8,  1'b1, 1'b0, 9'h1FF, 9'h1FF},
    {4'd9,  1'b0, 1'b0, 9'h1FF, 9'h1FF},
    {4'd15, 1'b0, 1'b0, 9'h1FF, 9'h1FF},
    {4'd7,  1'b1, 1'b1, 9'h1FF, 9'h1FF},
    {4'd1,  1'b1, 1'b0, 9'h1FF, 9'h1FD}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [111:0] p, exp_pkt, got;
    logic [111:0] rst_pkt;
    rst_pkt = mkpkt(0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0);
    tick(3);
    // R1 reset state
    chk("R1 reset packet", pkt_rd, rst_pkt);
    chk("R1 reset csb", {csb0, csb1}, {18{1'b1}});
    chk("R1 reset scan_out", scan_out, 0);
    rst_n = 1; tick(2);

    // table walk, parallel mode: R2 R5 R8 R10 R12
    for (int i = 0; i < 10; i++) begin
      p = mkpkt(VEC[i][23:20], 16'h0010 + 16'(i), 32'h1000_0000 + 32'(i), VEC[i][19], 1'b1, 1'b0,
                16'h0020, 32'h0, VEC[i][18], 1'b1, 4'h0);
      la_load(p | 112'h7);
      chk("R5 R2 parallel load", pkt_rd, p);
      chk("R8 csb0 decode", csb0, VEC[i][17:9]);
      chk("R10 csb1 decode", csb1, VEC[i][8:0]);
      chk("R12 addr0", a0, 16'h0010 + 16'(i));
    end

    // narrow write then read-back capture on memory 2
    p = mkpkt(2, 5, 32'hDEAD_BEEF, 0, 0, 1, 5, 0, 1, 1, 4'hA);
    la_load(p);
    chk("R11 narrow din0", d0, 64'h0000_0000_DEAD_BEEF);
    chk("R12 wmask and web", {wm0, wm1, web0, web1}, {4'hF, 4'hA, 1'b0, 1'b1});
    p = mkpkt(2, 5, 0, 0, 1, 0, 5, 0, 0, 1, 0);
    la_load(p);
    la_capture(p);
    exp_pkt = mkpkt(2, 5, 32'hDEAD_BEEF, 0, 1, 0, 5, 32'hDEAD_BEEF, 0, 1, 0);
    chk("R7 parallel capture both ports", pkt_rd, exp_pkt);

    // wide memory 8: folding and single-port capture
    p = mkpkt(8, 3, 32'hAAAA_5555, 0, 0, 1, 0, 0, 1, 0, 0);
    la_load(p);
    chk("R11 wide din0 fold", d0, 64'hAAAA_0000_0000_5555);
    p = mkpkt(8, 3, 0, 0, 1, 0, 3, 32'h1234_5678, 0, 1, 0);
    la_load(p);
    chk("R10 wide memory csb1", csb1, 9'h1FF);
    la_capture(p);
    exp_pkt = mkpkt(8, 3, 32'hAAAA_5555, 0, 1, 0, 3, 32'h1234_5678, 0, 1, 0);
    chk("R11 R7 wide unfold capture", pkt_rd, exp_pkt);

    // global disable: R9
    glob_csb = 1; tick(1);
    chk("R9 global off csb0", csb0, 9'h1FF);
    glob_csb = 0; tick(1);
    chk("R9 global released csb0", csb0, 9'h0FF);

    // serial mode full scan: R3
    mode_sel = 1; tick(4);
    p = mkpkt(2, 5, 0, 0, 1, 0, 16'hBEEF, 32'h0F0F_F0F0, 1, 1, 4'h3);
    for (int i = 0; i < 112; i++) begin
      got[111-i] = scan_out;
      scan_pulse(p[111-i], 1, 0);
    end
    chk("R3 scan out old packet", got, exp_pkt);
    chk("R3 scan in new packet", pkt_rd, p);

    // idle scan edge: R4; analyzer edge in serial mode: R6
    scan_pulse(1, 0, 0);
    chk("R4 idle scan edge", pkt_rd, p);
    la_load(mkpkt(1, 1, 1, 0, 0, 0, 1, 1, 0, 0, 0));
    chk("R6 analyzer ignored in serial", pkt_rd, p);

    // serial capture: port0 reads mem2, port1 disabled: R7
    scan_pulse(0, 0, 1);
    exp_pkt = mkpkt(2, 5, 32'hDEAD_BEEF, 0, 1, 0, 16'hBEEF, 32'h0F0F_F0F0, 1, 1, 4'h3);
    chk("R7 serial capture port0 only", pkt_rd, exp_pkt);

    // scan edge in parallel mode: R6
    mode_sel = 0; tick(4);
    scan_pulse(1, 1, 0);
    chk("R6 scan ignored in parallel", pkt_rd, exp_pkt);

    // reset mid-run: R1
    rst_n = 0; tick(2);
    chk("R1 reset again", pkt_rd, rst_pkt);
    chk("R1 csb after reset", {csb0, csb1}, {18{1'b1}});
    rst_n = 1; tick(2);
    finish_run();
  end
endmodule